// File: doc/BRIEF.md
# Audio Noise Gate with Hold Delay

The block gates one channel of signed PCM audio. Samples arrive one per strobe at the sample rate Fs. Each sample's magnitude is compared with a threshold taken from a coded table of dB levels relative to full scale. A boost bit moves the whole table up by 30 dB. The gate stays open while the signal is loud. After the signal has stayed under the threshold for a programmable hold time of 50 to 200 ms, the gain is driven down to a floor near -96 dB. A loud sample restores unity gain.

The gain moves in one of two ways. It can step per sample along an exponential ramp, or it can jump straight to its target. Either kind of change can also be made to wait for a zero crossing, with a timeout. The gated sample leaves through a register one clock after its strobe. Two unboosted threshold codes are reserved; selecting either one bypasses the gate.

Top module: `noise_gate`

## Requirements
- R1: With boost clear, threshold codes 0..5 select -64, -67, -70, -73, -76 and -82 dB. A sample counts as loud when |x| >= floor(2^(W-1) * 10^(dB/20)), and as quiet otherwise.
- R2: With boost set, threshold codes 0..7 select -34, -37, -40, -43, -46, -52, -58 and -64 dB, using the same loud/quiet rule as R1.
- R3: With boost clear, threshold codes 6 and 7 are reserved. Every strobed sample then appears unchanged at the output, and the gain returns to unity at once.
- R4: Let N = D*Fs/1000, where D is 50, 100, 150 or 200 ms for delay codes 0, 1, 2 and 3. The gate target becomes closed on the Nth consecutive quiet strobe. A loud sample clears the count and keeps the gate open, even when it lands on the Nth strobe.
- R5: The gain G is held as an integer where unity is 65536 and the floor is 1 (-96.3 dB). The output for a strobed sample x is floor(x*G/65536), using the gain in force before that strobe.
- R6: With soft ramp enabled, each strobe that may move the gain changes G by max(floor(G/64),1) toward the target (about 0.137 dB), clamped to the range 1..65536.
- R7: With soft ramp disabled, a permitted gain change sets G to the target in a single strobe.
- R8: With zero-cross enabled, a gain change is permitted only on a strobe whose sign bit differs from the sign bit of the previous strobed sample, or once 18*Fs/1000 strobes have been spent waiting.
- R9: A loud sample while the target is closed sets the target to unity on that same strobe. The gain then returns to unity under the rules of R6 to R8.
- R10: After reset, smp_o and smp_vld_o are 0. smp_vld_o is smp_vld_i delayed by one clock. smp_o changes only on the clock after a strobe.
- R11: The scaled result saturates to the signed W-bit range, so full-scale inputs at unity gain pass through exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | DATA_W | Signed input sample |
| thr_code_i | input | 3 | Threshold code |
| boost_i | input | 1 | Adds 30 dB to the threshold table |
| dly_code_i | input | 2 | Hold delay code |
| soft_en_i | input | 1 | Enables the per-sample gain ramp |
| zc_en_i | input | 1 | Enables zero-cross timing of gain changes |
| smp_vld_o | output | 1 | Output strobe |
| smp_o | output | DATA_W | Gated output sample |

## Verification
The hold counter and the level detector can act on the same strobe. A loud sample that arrives exactly on the Nth quiet strobe must keep the gate open. The bench provokes this for each delay code and judges it against its own model on every clock. In the same way, a zero crossing or a zero-cross timeout can coincide with a change of the gate target. In that case the gain must move toward the new target on that strobe. Runs of constant-sign samples followed by a single sign flip exercise this case.

// File: rtl/ng_pkg.sv
package ng_pkg;
  localparam int THR_Q = 24;

  // threshold as fraction of full scale, Q0.24; reserved -> all ones
  function automatic logic [THR_Q-1:0] thr_q24(input logic boost, input logic [2:0] code);
    logic [THR_Q-1:0] q;
    case ({boost, code})
      4'b1_000: q = 24'd334751;  // -34
      4'b1_001: q = 24'd236985;  // -37
      4'b1_010: q = 24'd167772;  // -40
      4'b1_011: q = 24'd118773;  // -43
      4'b1_100: q = 24'd84085;   // -46
      4'b1_101: q = 24'd42143;   // -52
      4'b1_110: q = 24'd21121;   // -58
      4'b1_111: q = 24'd10586;   // -64
      4'b0_000: q = 24'd10586;   // -64
      4'b0_001: q = 24'd7494;    // -67
      4'b0_010: q = 24'd5305;    // -70
      4'b0_011: q = 24'd3756;    // -73
      4'b0_100: q = 24'd2659;    // -76
      4'b0_101: q = 24'd1333;    // -82
      default:  q = '1;
    endcase
    return q;
  endfunction
endpackage

// File: rtl/ng_level.sv
module ng_level #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] smp_i,
  input  logic              boost_i,
  input  logic [2:0]        code_i,
  output logic              loud_o,
  output logic              dis_o
);
  import ng_pkg::*;
  // supports DATA_W <= 25
  localparam int SH = THR_Q - (DATA_W - 1);

  logic [DATA_W-1:0] mag;
  logic [THR_Q-1:0]  thr_lin;

  assign mag     = smp_i[DATA_W-1] ? (~smp_i + 1'b1) : smp_i;
  assign thr_lin = thr_q24(boost_i, code_i) >> SH;
  assign dis_o   = !boost_i && code_i[2] && code_i[1];
  assign loud_o  = dis_o || ({{(32-DATA_W){1'b0}}, mag} >= {{(32-THR_Q){1'b0}}, thr_lin});
endmodule

// File: rtl/ng_hold.sv
module ng_hold #(
  parameter int FS_HZ = 48000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       loud_i,
  input  logic [1:0] dly_i,
  output logic       shut_o
);
  localparam int UNIT = 50 * FS_HZ / 1000;
  localparam int MAXN = 4 * UNIT;
  localparam int CW   = $clog2(MAXN + 2);

  logic [CW-1:0] cnt_q, lim;
  logic          shut_q, reach;

  always_comb begin
    case (dly_i)
      2'd0:    lim = CW'(UNIT);
      2'd1:    lim = CW'(2 * UNIT);
      2'd2:    lim = CW'(3 * UNIT);
      default: lim = CW'(MAXN);
    endcase
  end

  assign reach  = (cnt_q + CW'(1)) >= lim;
  assign shut_o = !loud_i && (reach || shut_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else if (stb_i) begin
      if (loud_i) begin
        cnt_q  <= '0;
        shut_q <= 1'b0;
      end else begin
        shut_q <= reach || shut_q;
        if (cnt_q < lim) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R4
  hold_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && loud_i |=> cnt_q == '0 && !shut_q);
  // R4
  hold_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !loud_i && !shut_q && !reach |=> !shut_q);
endmodule

// File: rtl/ng_gain.sv
module ng_gain #(
  parameter int GAIN_FRAC = 16,
  parameter int STEP_SH   = 6,
  parameter int ZC_TO     = 864
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic               dis_i,
  input  logic               shut_i,
  input  logic               neg_i,
  input  logic               soft_en_i,
  input  logic               zc_en_i,
  output logic [GAIN_FRAC:0] gain_o
);
  localparam int GW = GAIN_FRAC + 1;
  localparam int ZW = $clog2(ZC_TO + 1);
  localparam logic [GW-1:0] UNITY = GW'(1) << GAIN_FRAC;
  localparam logic [GW-1:0] FLOOR = GW'(1);

  logic [GW-1:0] gain_q, tgt, delta, g_soft;
  logic [GW:0]   up_sum;
  logic [ZW-1:0] zc_q;
  logic          prev_neg_q, pend, ok, xing;

  assign tgt    = shut_i ? FLOOR : UNITY;
  assign pend   = gain_q != tgt;
  assign xing   = neg_i ^ prev_neg_q;
  assign ok     = !zc_en_i || xing || (zc_q >= ZW'(ZC_TO));
  assign delta  = ((gain_q >> STEP_SH) == '0) ? GW'(1) : (gain_q >> STEP_SH);
  assign up_sum = {1'b0, gain_q} + {1'b0, delta};

  always_comb begin
    if (shut_i) g_soft = (gain_q > delta + FLOOR) ? gain_q - delta : FLOOR;
    else        g_soft = (up_sum > {1'b0, UNITY}) ? UNITY : up_sum[GW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q     <= UNITY;
      zc_q       <= '0;
      prev_neg_q <= 1'b0;
    end else if (stb_i) begin
      prev_neg_q <= neg_i;
      if (dis_i) begin
        gain_q <= UNITY;
        zc_q   <= '0;
      end else if (pend && ok) begin
        gain_q <= soft_en_i ? g_soft : tgt;
        zc_q   <= '0;
      end else if (pend) begin
        if (zc_q < ZW'(ZC_TO)) zc_q <= zc_q + ZW'(1);
      end else begin
        zc_q <= '0;
      end
    end
  end

  assign gain_o = gain_q;

  // R6
  gain_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_q >= FLOOR && gain_q <= UNITY);
  // R10
  gain_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(gain_q));
  // R7
  hard_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !dis_i && !soft_en_i && ok |=> gain_q == ($past(shut_i) ? FLOOR : UNITY));
  // R8
  zc_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !dis_i && zc_en_i && !xing && zc_q < ZW'(ZC_TO) |=> $stable(gain_q));
  // R9
  reopen_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i && !dis_i && !shut_i |=> gain_q >= $past(gain_q));
endmodule

// File: rtl/noise_gate.sv
module noise_gate #(
  parameter int DATA_W    = 16,
  parameter int FS_HZ     = 48000,
  parameter int GAIN_FRAC = 16,
  parameter int STEP_SH   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_vld_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic [2:0]               thr_code_i,
  input  logic                     boost_i,
  input  logic [1:0]               dly_code_i,
  input  logic                     soft_en_i,
  input  logic                     zc_en_i,
  output logic                     smp_vld_o,
  output logic signed [DATA_W-1:0] smp_o
);
  localparam int ZC_TO = 18 * FS_HZ / 1000;
  localparam int PW    = DATA_W + GAIN_FRAC + 2;
  localparam logic signed [PW-1:0] S_MAX = PW'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] S_MIN = -(PW'(64'sd1 <<< (DATA_W - 1)));

  logic               loud, dis, shut;
  logic [GAIN_FRAC:0] gain;
  logic signed [PW-1:0]     prod, scaled;
  logic signed [DATA_W-1:0] sat;

  ng_level #(.DATA_W(DATA_W)) u_level (
    .smp_i(smp_i), .boost_i(boost_i), .code_i(thr_code_i),
    .loud_o(loud), .dis_o(dis)
  );

  ng_hold #(.FS_HZ(FS_HZ)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(smp_vld_i), .loud_i(loud),
    .dly_i(dly_code_i), .shut_o(shut)
  );

  ng_gain #(.GAIN_FRAC(GAIN_FRAC), .STEP_SH(STEP_SH), .ZC_TO(ZC_TO)) u_gain (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(smp_vld_i), .dis_i(dis), .shut_i(shut),
    .neg_i(smp_i[DATA_W-1]), .soft_en_i(soft_en_i), .zc_en_i(zc_en_i), .gain_o(gain)
  );

  assign prod   = $signed(smp_i) * $signed({1'b0, gain});
  assign scaled = prod >>> GAIN_FRAC;

  always_comb begin
    if (scaled > S_MAX)      sat = S_MAX[DATA_W-1:0];
    else if (scaled < S_MIN) sat = S_MIN[DATA_W-1:0];
    else                     sat = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_vld_o <= 1'b0;
      smp_o     <= '0;
    end else begin
      smp_vld_o <= smp_vld_i;
      if (smp_vld_i) smp_o <= dis ? smp_i : sat;
    end
  end

  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && dis |=> smp_o == $past(smp_i));
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(smp_o));
  // R5
  no_amplify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && !smp_i[DATA_W-1] |=> !smp_o[DATA_W-1]);
endmodule

// File: tb/tb_noise_gate.sv
module tb_noise_gate;
  localparam int DW    = 16;
  localparam int FS    = 8000;
  localparam int UNIT  = 50 * FS / 1000;
  localparam int ZC_TO = 18 * FS / 1000;
  localparam int UNITY = 65536;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_vld_i = 1'b0;
  logic signed [DW-1:0] smp_i = '0;
  logic [2:0] thr_code_i = '0;
  logic boost_i = 1'b0;
  logic [1:0] dly_code_i = '0;
  logic soft_en_i = 1'b0;
  logic zc_en_i = 1'b0;
  logic smp_vld_o;
  logic signed [DW-1:0] smp_o;

  int n_chk = 0, n_err = 0;
  int m_g = UNITY, m_cnt = 0, m_zc = 0, m_y = 0;
  bit m_shut = 0, m_prev_neg = 0, m_v = 0, done = 0;

  always #10 clk_i = ~clk_i;

  noise_gate #(.DATA_W(DW), .FS_HZ(FS)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .thr_code_i(thr_code_i), .boost_i(boost_i), .dly_code_i(dly_code_i),
    .soft_en_i(soft_en_i), .zc_en_i(zc_en_i), .smp_vld_o(smp_vld_o), .smp_o(smp_o)
  );

  function automatic int thr_of(int b, int c);
    real db;
    if (b != 0) begin
      case (c)
        0: db = -34.0; 1: db = -37.0; 2: db = -40.0; 3: db = -43.0;
        4: db = -46.0; 5: db = -52.0; 6: db = -58.0; default: db = -64.0;
      endcase
    end else begin
      case (c)
        0: db = -64.0; 1: db = -67.0; 2: db = -70.0; 3: db = -73.0;
        4: db = -76.0; default: db = -82.0;
      endcase
    end
    return int'($floor((2.0 ** (DW - 1)) * (10.0 ** (db / 20.0))));
  endfunction

  task automatic model_step(input bit v, input int x);
    bit dis, loud, neg, ok;
    int mag, n, tgt, d;
    longint p;
    m_v = v;
    if (!v) return;
    neg  = x < 0;
    mag  = neg ? -x : x;
    dis  = !boost_i && thr_code_i >= 6;
    loud = dis || mag >= thr_of(boost_i, thr_code_i);
    n    = (dly_code_i + 1) * UNIT;
    if (dis) m_y = x;
    else begin
      p = (longint'(x) * m_g) >>> 16;
      m_y = p > 32767 ? 32767 : (p < -32768 ? -32768 : int'(p));
    end
    if (loud) begin m_cnt = 0; m_shut = 0; end
    else begin
      if (m_cnt + 1 >= n) m_shut = 1;
      if (m_cnt < n) m_cnt++;
    end
    if (dis) begin m_g = UNITY; m_zc = 0; end
    else begin
      tgt = m_shut ? 1 : UNITY;
      ok  = !zc_en_i || (neg != m_prev_neg) || m_zc >= ZC_TO;
      if (m_g != tgt) begin
        if (ok) begin
          d = (m_g >> 6) == 0 ? 1 : (m_g >> 6);
          if (!soft_en_i) m_g = tgt;
          else if (m_shut) m_g = (m_g - d < 1) ? 1 : m_g - d;
          else m_g = (m_g + d > UNITY) ? UNITY : m_g + d;
          m_zc = 0;
        end else if (m_zc < ZC_TO) m_zc++;
      end else m_zc = 0;
    end
    m_prev_neg = neg;
  endtask

  task automatic chk(input string tag);
    n_chk++;
    if (int'(smp_o) != m_y || smp_vld_o != m_v) begin
      n_err++;
      $display("FAIL %s: smp_o=%0d vld=%0b expected %0d vld=%0b at %0t",
               tag, smp_o, smp_vld_o, m_y, m_v, $time);
    end
  endtask

  task automatic cyc(input bit v, input int x, input string tag);
    smp_vld_i = v;
    smp_i     = DW'(x);
    @(posedge clk_i);
    model_step(v, x);
    @(negedge clk_i);
    chk(tag);
  endtask

  // one strobe then one idle clock per sample
  task automatic run(input int n, input int amp, input bit alt, input string tag);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, (alt && (i % 2 == 1)) ? -amp : amp, tag);
      cyc(1'b0, 0, tag);
    end
  endtask

  task automatic cfg(input int b, input int c, input int d, input bit s, input bit z);
    boost_i = b[0]; thr_code_i = 3'(c); dly_code_i = 2'(d);
    soft_en_i = s; zc_en_i = z;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    n_chk++;
    if (smp_o !== '0 || smp_vld_o !== 1'b0) begin
      n_err++;
      $display("FAIL R10: reset smp_o=%0d vld=%0b expected 0 vld=0", smp_o, smp_vld_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10");

    // R1 / R2: every table entry, exact boundary
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 8; c++) begin
        int t;
        if (b == 0 && c >= 6) continue;
        t = thr_of(b, c);
        cfg(b, c, 0, 0, 0);
        run(2, 1000, 1, b ? "R2" : "R1");
        run(UNIT, t, 1, b ? "R2" : "R1");
        run(UNIT + 2, t - 1, 1, b ? "R2" : "R1");
      end
    end

    // R4: loud sample on the Nth quiet strobe, every delay code
    for (int d = 0; d < 4; d++) begin
      cfg(0, 0, d, 0, 0);
      run(2, 1000, 1, "R4");
      run((d + 1) * UNIT - 1, 5, 1, "R4");
      run(1, 1000, 1, "R4");
      run((d + 1) * UNIT + 3, 5, 1, "R4");
      run(3, -30000, 0, "R5");
    end

    // R9 hard reopen
    run(4, 1200, 1, "R9");

    // R6 soft ramp down, R9 soft ramp up
    cfg(0, 0, 0, 1, 0);
    run(UNIT + 900, 7, 1, "R6");
    run(900, 1500, 1, "R9");

    // R8 zero-cross: timeout path, then crossing path
    cfg(0, 0, 0, 0, 1);
    run(UNIT + 5, 5, 0, "R8");
    run(ZC_TO + 4, 5, 0, "R8");
    run(ZC_TO + 4, 1000, 0, "R8");
    run(UNIT, 5, 0, "R8");
    run(3, -5, 0, "R8");
    cfg(0, 0, 0, 1, 1);
    run(200, 1000, 1, "R8");

    // R3 reserved codes bypass, even when closed
    cfg(0, 0, 0, 0, 0);
    run(UNIT + 2, 5, 1, "R3");
    cfg(0, 6, 0, 0, 0);
    run(5, 5, 1, "R3");
    cfg(0, 7, 0, 0, 0);
    run(UNIT + 10, 3, 1, "R3");

    // R11 full scale at unity and at floor
    cfg(0, 0, 0, 0, 0);
    run(2, 1000, 1, "R11");
    cyc(1'b1, 32767, "R11");
    cyc(1'b1, -32768, "R11");
    cyc(1'b0, 0, "R11");
    run(UNIT + 1, 4, 1, "R11");
    cyc(1'b1, -32768, "R11");
    cyc(1'b1, 32767, "R11");
    cyc(1'b0, 0, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule